// File: doc/BRIEF.md
# Cascaded System Clock Enable Generator

This block turns one root clock tick stream into three rate-reduced clock enables for a chip's clock tree: a core enable, a high-speed bus enable and a peripheral bus enable. Everything runs on one fast clock. Root cycles arrive as tick qualifiers on that clock, one from the PLL and one from the crystal reference. A configuration word picks the root source and the three divisors.

The core and bus divisors come from fixed lookup tables whose entries are not all powers of two. The peripheral enable is not counted from the root. It is counted from bus enables, so it always falls on a bus enable. A set of DMA channel enables is fanned out from the bus enable.

A divisor change never cuts a period short. Each divider finishes its running period with the old divisor and picks up the new one at its terminal count.

Top module: `cbd_clkgen`

## Requirements
- R1: The core enable divides the root tick rate by the value chosen by cfg_word[27:25]: code 0 selects 1, code 1 selects 2, code 2 selects 4, code 3 selects 8, code 4 selects 16, and codes 5, 6 and 7 select 1.
- R2: The bus enable divides the root tick rate by the value chosen by cfg_word[22:20]: code 0 selects 1, 1 selects 2, 2 selects 4, 3 selects 5, 4 selects 6, 5 selects 8, 6 selects 16 and 7 selects 32.
- R3: The peripheral enable divides the bus enable rate by 1, 2, 4 or 8 for cfg_word[19:18] = 0, 1, 2 or 3. It is asserted only in a cycle where the bus enable is also asserted.
- R4: When cfg_word[23] is 1, the root is pll_tick. When it is 0, the root is xtal_tick and pll_tick has no effect on any enable.
- R5: Every bit of dma_ce equals bus_ce in every cycle.
- R6: A divisor of 1 asserts that enable on every root tick.
- R7: A divisor change reaches a divider only at its terminal count. The running period completes with the old divisor and the next period uses the new one.
- R8: While rst_n is low, and in the first clock after rst_n rises, all enables are 0. The divisors are captured in that first clock, and a tick in that clock is not counted. With divisor N, the first pulse then falls on the Nth counted tick.
- R9: Each enable is high for one clock, and only in a cycle whose root tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock on which the tick qualifiers are presented |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | One-cycle qualifier per PLL root cycle |
| xtal_tick | input | 1 | One-cycle qualifier per crystal reference cycle |
| cfg_word | input | CFG_W | Divisor codes and root-select bit |
| core_ce | output | 1 | Core clock enable |
| bus_ce | output | 1 | High-speed bus clock enable |
| per_ce | output | 1 | Peripheral bus clock enable |
| dma_ce | output | NUM_DMA | Per-channel DMA clock enables |

## Verification
The bench builds the block with its defaults: a 32-bit configuration word, the root-select bit at position 23 and twelve DMA channels. This brings every table code within reach, including the non-power-of-two bus divisors 5 and 6 and the aliased core codes 5 to 7. The twelve channels show that the fan-out reaches every channel. Root tick patterns with gaps, a crystal-rooted run, divisor changes in mid-period and a reset in mid-run exercise the rule that changes wait for the terminal count, and the quiet start after reset.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

   // Field positions are behaviour: the divisor codes live here.
   localparam int CORE_LSB = 25;
   localparam int BUS_LSB  = 20;
   localparam int PER_LSB  = 18;
   localparam int TOP_BIT  = 27;

   // Largest entry of each table.
   localparam int CORE_MAX = 16;
   localparam int BUS_MAX  = 32;
   localparam int PER_MAX  = 8;

   function automatic int unsigned core_div(input logic [2:0] code);
      case (code)
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         3'd4:    return 16;
         default: return 1;
      endcase
   endfunction

   function automatic int unsigned bus_div(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 5;
         3'd4:    return 6;
         3'd5:    return 8;
         3'd6:    return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int unsigned per_div(input logic [1:0] code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/cbd_root_sel.sv
module cbd_root_sel (
   input  logic use_pll,
   input  logic pll_tick,
   input  logic xtal_tick,
   output logic root_tick
);

   always_comb begin
      if (use_pll) root_tick = pll_tick;
      else         root_tick = xtal_tick;
   end

endmodule

// File: rtl/cbd_stage.sv
module cbd_stage #(
   parameter  int MAX_DIV = 16,
   localparam int DW      = $clog2(MAX_DIV + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [DW-1:0] div_in,
   output logic          pulse
);

   localparam logic [DW-1:0] ONE = DW'(1);

   if (MAX_DIV < 1) begin : g_bad_max
      $error("cbd_stage: MAX_DIV must be at least 1");
   end

   logic [DW-1:0] cnt;
   logic [DW-1:0] div_q;
   logic          armed;
   logic          term;

   assign term  = (cnt == div_q - ONE);
   assign pulse = armed & tick & term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_q <= ONE;
         armed <= 1'b0;
      end else if (!armed) begin
         div_q <= div_in;
         cnt   <= '0;
         armed <= 1'b1;
      end else if (tick) begin
         if (term) begin
            cnt   <= '0;
            div_q <= div_in;
         end else begin
            cnt <= cnt + ONE;
         end
      end
   end

endmodule

// File: rtl/cbd_clkgen.sv
module cbd_clkgen #(
   parameter int CFG_W   = 32,
   parameter int BYP_BIT = 23,
   parameter int NUM_DMA = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pll_tick,
   input  logic               xtal_tick,
   input  logic [CFG_W-1:0]   cfg_word,
   output logic               core_ce,
   output logic               bus_ce,
   output logic               per_ce,
   output logic [NUM_DMA-1:0] dma_ce
);

   import cbd_pkg::*;

   localparam int CDW = $clog2(CORE_MAX + 1);
   localparam int BDW = $clog2(BUS_MAX + 1);
   localparam int PDW = $clog2(PER_MAX + 1);

   if (CFG_W <= TOP_BIT) begin : g_bad_width
      $error("cbd_clkgen: CFG_W too small for the divisor fields");
   end
   if (BYP_BIT >= CFG_W || (BYP_BIT >= PER_LSB && BYP_BIT <= TOP_BIT && BYP_BIT != 23 && BYP_BIT != 24))
   begin : g_bad_byp
      $error("cbd_clkgen: BYP_BIT overlaps a divisor field or lies outside the word");
   end
   if (NUM_DMA < 1) begin : g_bad_dma
      $error("cbd_clkgen: NUM_DMA must be at least 1");
   end

   logic [2:0]     core_code;
   logic [2:0]     bus_code;
   logic [1:0]     per_code;
   logic [CDW-1:0] core_dv;
   logic [BDW-1:0] bus_dv;
   logic [PDW-1:0] per_dv;
   logic           root_tick;
   logic           unused_cfg_bits;

   assign core_code       = cfg_word[CORE_LSB +: 3];
   assign bus_code        = cfg_word[BUS_LSB +: 3];
   assign per_code        = cfg_word[PER_LSB +: 2];
   assign unused_cfg_bits = ^cfg_word;

   assign core_dv = CDW'(core_div(core_code));
   assign bus_dv  = BDW'(bus_div(bus_code));
   assign per_dv  = PDW'(per_div(per_code));

   cbd_root_sel u_root (
      .use_pll   (cfg_word[BYP_BIT]),
      .pll_tick  (pll_tick),
      .xtal_tick (xtal_tick),
      .root_tick (root_tick)
   );

   cbd_stage #(.MAX_DIV(CORE_MAX)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (root_tick),
      .div_in (core_dv),
      .pulse  (core_ce)
   );

   cbd_stage #(.MAX_DIV(BUS_MAX)) u_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (root_tick),
      .div_in (bus_dv),
      .pulse  (bus_ce)
   );

   // Peripheral divider counts bus enables, not root ticks.
   cbd_stage #(.MAX_DIV(PER_MAX)) u_per (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (bus_ce),
      .div_in (per_dv),
      .pulse  (per_ce)
   );

   for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
      assign dma_ce[g] = bus_ce;
   end

endmodule

// File: rtl/cbd_clkgen_chk.sv
module cbd_clkgen_chk #(
   parameter int CORE_MAX = 16,
   parameter int BUS_MAX  = 32
) (
   input logic clk,
   input logic rst_n,
   input logic byp_bit,
   input logic pll_tick,
   input logic xtal_tick,
   input logic core_ce,
   input logic bus_ce,
   input logic per_ce
);

   logic       started;
   logic       rt;
   logic [5:0] core_gap;
   logic [5:0] bus_gap;

   assign rt = byp_bit ? pll_tick : xtal_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         core_gap <= '0;
         bus_gap  <= '0;
      end else begin
         started <= 1'b1;
         if (started && rt) begin
            core_gap <= core_ce ? 6'd0 : core_gap + 6'd1;
            bus_gap  <= bus_ce  ? 6'd0 : bus_gap  + 6'd1;
         end
      end
   end

   // R1: the longest core period is CORE_MAX root ticks
   p_core_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (started && rt && core_gap == 6'(CORE_MAX - 1)) |-> core_ce);

   // R2: the longest bus period is BUS_MAX root ticks
   p_bus_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (started && rt && bus_gap == 6'(BUS_MAX - 1)) |-> bus_ce);

   // R3: peripheral enable sits on a bus enable
   p_per_in_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      per_ce |-> bus_ce);

   // R4: crystal-rooted with no crystal tick gives no root-rate enable
   p_xtal_root_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_bit && !xtal_tick) |-> (!core_ce && !bus_ce));

   // R8: nothing fires in the first clock after reset
   p_quiet_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (!core_ce && !bus_ce && !per_ce));

   // R9: an enable implies a root tick in the same cycle
   p_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ce || bus_ce) |-> rt);

endmodule

bind cbd_clkgen cbd_clkgen_chk #(
   .CORE_MAX (cbd_pkg::CORE_MAX),
   .BUS_MAX  (cbd_pkg::BUS_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .byp_bit   (cfg_word[BYP_BIT]),
   .pll_tick  (pll_tick),
   .xtal_tick (xtal_tick),
   .core_ce   (core_ce),
   .bus_ce    (bus_ce),
   .per_ce    (per_ce)
);

// File: tb/cbd_clkgen_test.sv
module cbd_clkgen_test;

   localparam int NDMA = 12;

   typedef struct {
      logic        c;
      logic        b;
      logic        p;
      string       tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pll_tick = 1'b0;
   logic            xtal_tick = 1'b0;
   logic [31:0]     cfg_word = '0;
   logic            core_ce, bus_ce, per_ce;
   logic [NDMA-1:0] dma_ce;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   exp_t sb[$];

   // reference state, built from the requirements
   bit m_arm = 0;
   int dc = 1, db = 1, dp = 1;
   int cc = 0, cb = 0, cp = 0;

   always #5 clk = ~clk;

   cbd_clkgen uut (
      .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
      .cfg_word(cfg_word), .core_ce(core_ce), .bus_ce(bus_ce),
      .per_ce(per_ce), .dma_ce(dma_ce)
   );

   function automatic int t_core(input int code);
      case (code) 1: return 2; 2: return 4; 3: return 8; 4: return 16; default: return 1; endcase
   endfunction
   function automatic int t_bus(input int code);
      case (code) 0: return 1; 1: return 2; 2: return 4; 3: return 5;
         4: return 6; 5: return 8; 6: return 16; default: return 32; endcase
   endfunction

   function automatic logic [31:0] mk_cfg(input int c, input int b, input int p, input bit use_pll);
      logic [31:0] w = '0;
      w[27:25] = 3'(c);
      w[22:20] = 3'(b);
      w[19:18] = 2'(p);
      w[23]    = use_pll;
      return w;
   endfunction

   task automatic drive(input bit rst, input logic [31:0] cfg, input bit pt, input bit xt, input string tag);
      exp_t e;
      bit root;
      @(negedge clk);
      rst_n = rst; cfg_word = cfg; pll_tick = pt; xtal_tick = xt;
      e.tag = tag; e.c = 0; e.b = 0; e.p = 0;
      if (!rst) begin
         m_arm = 0;
      end else if (!m_arm) begin
         dc = t_core(int'(cfg[27:25])); db = t_bus(int'(cfg[22:20])); dp = 1 << cfg[19:18];
         cc = 0; cb = 0; cp = 0; m_arm = 1;
      end else begin
         root = cfg[23] ? pt : xt;
         e.c = root && (cc == dc - 1);
         e.b = root && (cb == db - 1);
         e.p = e.b && (cp == dp - 1);
         if (root) begin
            if (e.c) begin cc = 0; dc = t_core(int'(cfg[27:25])); end else cc++;
            if (e.b) begin cb = 0; db = t_bus(int'(cfg[22:20])); end else cb++;
         end
         if (e.b) begin
            if (e.p) begin cp = 0; dp = 1 << cfg[19:18]; end else cp++;
         end
      end
      sb.push_back(e);
   endtask

   task automatic run(input int n, input logic [31:0] cfg, input int pper, input int xper, input string tag);
      for (int i = 0; i < n; i++) begin
         drive(1'b1, cfg, (cyc % pper) == 0, (cyc % xper) == 0, tag);
         cyc++;
      end
   endtask

   task automatic cmp(input logic act, input logic exp, input string what, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // monitor: pops one expected item per cycle and compares
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(core_ce, e.c, "core_ce R1", e.tag);
            cmp(bus_ce,  e.b, "bus_ce R2",  e.tag);
            cmp(per_ce,  e.p, "per_ce R3",  e.tag);
            cmp(dma_ce == {NDMA{e.b}}, 1'b1, "dma_ce R5", e.tag);
         end
      end
   end

   initial begin
      #(50000 * 10);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] w;
      // R8: held in reset with ticks present
      w = mk_cfg(2, 3, 1, 1);
      for (int i = 0; i < 6; i++) drive(1'b0, w, 1, 1, "R8");
      // R8: first clock after release ignored, quiet until first full period
      run(1, w, 1, 1, "R8");
      run(60, w, 1, 1, "R8");
      // R7: change in mid-period to the largest divisors
      run(3, mk_cfg(4, 7, 3, 1), 1, 1, "R7");
      run(300, mk_cfg(4, 7, 3, 1), 1, 1, "R7");
      // R6 and R1: core alias code 6 is divide-by-1, bus and peripheral by 1
      run(40, mk_cfg(6, 0, 0, 1), 1, 1, "R6");
      run(40, mk_cfg(5, 0, 0, 1), 2, 1, "R1");
      // R2: divide by 6, gapped ticks
      run(150, mk_cfg(3, 4, 2, 1), 2, 1, "R2");
      // R4: crystal root, pll ticks every cycle must not count
      run(200, mk_cfg(1, 1, 1, 0), 1, 3, "R4");
      run(120, mk_cfg(7, 2, 3, 0), 1, 2, "R4");
      // R9 and R8: reset in mid-run, restart with new divisors
      drive(1'b0, mk_cfg(2, 5, 2, 1), 1, 1, "R8");
      drive(1'b0, mk_cfg(2, 5, 2, 1), 1, 1, "R8");
      run(1, mk_cfg(2, 5, 2, 1), 1, 1, "R8");
      run(120, mk_cfg(2, 5, 2, 1), 3, 1, "R9");
      @(negedge clk);
      @(negedge clk);
      #6;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule